// File: doc/BRIEF.md
# VGA 640x480 Sync Timing Generator

This block produces the raster timing for a 640x480 display refreshed at about 60 Hz. It advances one step for each pulse of a pixel-rate enable, nominally 25.175 MHz. It drives active-low horizontal and vertical sync and an active-video flag. It also reports the zero-based column and line of the pixel being shown. Pixel fetch and colour generation sit downstream and consume these outputs.

The horizontal position counter is one-based. After reset it starts at 1, counts to 800 and then reloads. Every sync and active-video boundary is taken from a compare of that counter and captured in a register, so no edge comes from combinational decode. The decodes are registered on the same enable as the counter, so sync and active-video always change together. A strap input, `restart_at_zero`, changes the reload value to 0 and moves the terminal count to 799. The line is still 800 enables long, but it now carries 641 active pixels, and the back porch loses one pixel.

All porch, sync and active sizes are parameters whose defaults give the standard 640x480 geometry: 800 enables per line and 525 lines per frame.

Top module: `vga_sync_gen`

## Requirements
- R1: While `rst_n` is low, `hsync_n` and `vsync_n` are 1, and `video_on`, `col` and `row` are 0.
- R2: With the strap low, a line is 800 enables long. After reset the first line starts with the first enable, and the falling edges of `hsync_n` are exactly 800 enables apart.
- R3: `hsync_n` is low for 96 enables. It first falls on the 657th enable after reset, which is 16 enables after the last active pixel. It rises 48 enables before the next line's first active pixel, and `video_on` is never high while `hsync_n` is low.
- R4: With the strap low, `video_on` is high for 640 consecutive enables per active line, starting on the first enable after reset. During that run `col` counts 0 up to 639, one step per enable.
- R5: The line index advances once per completed line. A frame has V_ACTIVE+V_FP+V_SYNC+V_BP lines, which is 525 by default. `vsync_n` falls on the first enable of line V_ACTIVE+V_FP (line 490 by default) and stays low for V_SYNC lines, which is 2 by default.
- R6: `video_on` is high only on lines 0 to V_ACTIVE-1. There `row` equals the line index, and `row` is 0 on other lines. `col` is 0 whenever the horizontal position is outside the active span, and `video_on` is low throughout vertical sync.
- R7: A cycle with `pix_en` low changes no output and no counter. With `pix_en` high on every other clock, every timing interval doubles in clock cycles.
- R8: With `restart_at_zero` high, every line after the first wrap runs counter values 0 to 799. That gives 800 enables per line and 641 active pixels, with `col` running 0 to 640. Sync width is unchanged at 96 enables, and the back porch from the `hsync_n` rise to the next active pixel is 47 enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable; one raster step per high cycle |
| restart_at_zero | input | 1 | Strap: horizontal counter reloads to 0 and the line holds 641 active pixels |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| video_on | output | 1 | High while the current pixel lies in the active area |
| col | output | $clog2(H_ACTIVE+1) | Zero-based active column; 0 outside the active span |
| row | output | $clog2(V_ACTIVE) | Zero-based active line; 0 outside the active lines |

## Verification
A horizontal counter that is off by one, or a reload value that is wrong, appears within the first line. It moves the 657th-enable sync fall, shortens or lengthens the 640-pixel active run, or breaks the 800-enable spacing of sync edges. A line counter that steps at the wrong time misplaces the vsync fall and alters the number of active pixels per frame, so the bench instantiates the block with a short vertical geometry and observes two whole frames. A decode register that ignores the enable shows up as an output change across a cycle with `pix_en` low. A wrong strap path changes the 641-pixel run or the 47-enable back porch on the second line after reset.

// File: rtl/vga_tim_pkg.sv
package vga_tim_pkg;

   // Registered state of one axis decode.
   typedef struct packed {
      logic active;
      logic in_sync;
   } axis_state_t;

   // Inclusive span test on a counter value.
   function automatic logic in_span(input int unsigned v,
                                    input int unsigned lo,
                                    input int unsigned hi);
      return (v >= lo) && (v <= hi);
   endfunction

endpackage

// File: rtl/vga_hcount.sv
module vga_hcount #(
   parameter int H_TOTAL = 800,
   parameter int CNT_W   = $clog2(H_TOTAL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic             restart_at_zero,
   output logic [CNT_W-1:0] hcnt,
   output logic             line_end
);

   localparam logic [CNT_W-1:0] TERM_ONE  = CNT_W'(H_TOTAL);
   localparam logic [CNT_W-1:0] TERM_ZERO = CNT_W'(H_TOTAL - 1);

   if (H_TOTAL < 4) begin : g_bad_total
      $error("vga_hcount: H_TOTAL too small");
   end
   if ((1 << CNT_W) <= H_TOTAL) begin : g_bad_width
      $error("vga_hcount: CNT_W cannot hold H_TOTAL");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_c;
   logic [CNT_W-1:0] start_c;
   logic             at_term;

   assign term_c  = restart_at_zero ? TERM_ZERO : TERM_ONE;
   assign start_c = restart_at_zero ? '0 : CNT_W'(1);
   assign at_term = (cnt_q >= term_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(1);
      end else if (pix_en) begin
         cnt_q <= at_term ? start_c : cnt_q + CNT_W'(1);
      end
   end

   assign hcnt     = cnt_q;
   assign line_end = pix_en & at_term;

   // R2
   hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(H_TOTAL));

   // R7
   hcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(cnt_q));

endmodule

// File: rtl/vga_vcount.sv
module vga_vcount #(
   parameter int V_TOTAL = 525,
   parameter int CNT_W   = $clog2(V_TOTAL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] vcnt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(V_TOTAL - 1);

   if (V_TOTAL < 2) begin : g_bad_total
      $error("vga_vcount: V_TOTAL too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign vcnt = cnt_q;

   // R5
   vstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> $past(step));

   // R5
   vrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/vga_axis_dec.sv
module vga_axis_dec
   import vga_tim_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int POS_W   = 10,
   parameter int ACT_HI  = 640,
   parameter int SYNC_LO = 657,
   parameter int SYNC_HI = 752
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] base,
   output logic             active,
   output logic             sync_n,
   output logic [POS_W-1:0] pos
);

   if (POS_W > CNT_W) begin : g_bad_pos
      $error("vga_axis_dec: POS_W wider than CNT_W");
   end
   if (SYNC_HI < SYNC_LO) begin : g_bad_sync
      $error("vga_axis_dec: sync span reversed");
   end
   if (SYNC_LO <= ACT_HI) begin : g_bad_overlap
      $error("vga_axis_dec: sync overlaps active span");
   end

   axis_state_t      st_q;
   logic [POS_W-1:0] pos_q;
   logic             hit_act;
   logic             hit_sync;
   logic [CNT_W-1:0] offset;

   assign hit_act  = in_span(int'(cnt), int'(base), ACT_HI);
   assign hit_sync = in_span(int'(cnt), SYNC_LO, SYNC_HI);
   assign offset   = cnt - base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         pos_q <= '0;
      end else if (pix_en) begin
         st_q.active  <= hit_act;
         st_q.in_sync <= hit_sync;
         pos_q        <= hit_act ? offset[POS_W-1:0] : '0;
      end
   end

   assign active = st_q.active;
   assign sync_n = ~st_q.in_sync;
   assign pos    = pos_q;

   // R6
   idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_q.active |-> (pos_q == '0));

   // R3
   sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_q.active && st_q.in_sync));

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BP     = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BP     = 33
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pix_en,
   input  logic                          restart_at_zero,
   output logic                          hsync_n,
   output logic                          vsync_n,
   output logic                          video_on,
   output logic [$clog2(H_ACTIVE+1)-1:0] col,
   output logic [$clog2(V_ACTIVE)-1:0]   row
);

   localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
   localparam int HC_W    = $clog2(H_TOTAL + 1);
   localparam int VC_W    = $clog2(V_TOTAL);
   localparam int COL_W   = $clog2(H_ACTIVE + 1);
   localparam int ROW_W   = $clog2(V_ACTIVE);

   if (H_FP < 1 || H_SYNC < 1 || H_BP < 2) begin : g_bad_h
      $error("vga_sync_gen: horizontal porch or sync too short");
   end
   if (V_ACTIVE < 2 || V_SYNC < 1 || V_FP < 1 || V_BP < 1) begin : g_bad_v
      $error("vga_sync_gen: vertical geometry too short");
   end

   logic [HC_W-1:0] hcnt;
   logic [HC_W-1:0] h_base;
   logic [VC_W-1:0] vcnt;
   logic            line_end;
   logic            h_act;
   logic            v_act;

   assign h_base = {{(HC_W-1){1'b0}}, ~restart_at_zero};

   vga_hcount #(
      .H_TOTAL (H_TOTAL),
      .CNT_W   (HC_W)
   ) u_hcnt (
      .clk             (clk),
      .rst_n           (rst_n),
      .pix_en          (pix_en),
      .restart_at_zero (restart_at_zero),
      .hcnt            (hcnt),
      .line_end        (line_end)
   );

   vga_vcount #(
      .V_TOTAL (V_TOTAL),
      .CNT_W   (VC_W)
   ) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (line_end),
      .vcnt  (vcnt)
   );

   vga_axis_dec #(
      .CNT_W   (HC_W),
      .POS_W   (COL_W),
      .ACT_HI  (H_ACTIVE),
      .SYNC_LO (H_ACTIVE + H_FP + 1),
      .SYNC_HI (H_ACTIVE + H_FP + H_SYNC)
   ) u_hdec (
      .clk    (clk),
      .rst_n  (rst_n),
      .pix_en (pix_en),
      .cnt    (hcnt),
      .base   (h_base),
      .active (h_act),
      .sync_n (hsync_n),
      .pos    (col)
   );

   vga_axis_dec #(
      .CNT_W   (VC_W),
      .POS_W   (ROW_W),
      .ACT_HI  (V_ACTIVE - 1),
      .SYNC_LO (V_ACTIVE + V_FP),
      .SYNC_HI (V_ACTIVE + V_FP + V_SYNC - 1)
   ) u_vdec (
      .clk    (clk),
      .rst_n  (rst_n),
      .pix_en (pix_en),
      .cnt    (vcnt),
      .base   ('0),
      .active (v_act),
      .sync_n (vsync_n),
      .pos    (row)
   );

   assign video_on = h_act & v_act;

   // R3
   hsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n |-> !video_on);

   // R6
   vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> !video_on);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(hsync_n) && $stable(vsync_n) && $stable(video_on)));

endmodule

// File: tb/tb_vga_sync_gen.sv
`timescale 1ns/1ps
module tb_vga_sync_gen;

   localparam int VA = 6;
   localparam int VF = 2;
   localparam int VS = 2;
   localparam int VB = 3;
   localparam int VT = VA + VF + VS + VB;
   localparam int HT = 800;
   localparam int COL_W = $clog2(641);
   localparam int ROW_W = $clog2(VA);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_en = 1'b0;
   logic restart_at_zero = 1'b0;
   logic gate_mode = 1'b0;
   logic hsync_n, vsync_n, video_on;
   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int cyc = 0;
   int hs_fall_n, hs_rise_n, vs_fall_n, vs_rise_n, von_rise_n, von_fall_n, von_hi_n;
   int hs_fall_t, hs_rise_t, vs_fall_t, vs_rise_t, von_rise_t, von_fall_t;
   logic p_hs = 1'b1, p_vs = 1'b1, p_von = 1'b0;

   always #2 clk = ~clk;

   vga_sync_gen #(
      .V_ACTIVE (VA),
      .V_FP     (VF),
      .V_SYNC   (VS),
      .V_BP     (VB)
   ) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .pix_en          (pix_en),
      .restart_at_zero (restart_at_zero),
      .hsync_n         (hsync_n),
      .vsync_n         (vsync_n),
      .video_on        (video_on),
      .col             (col),
      .row             (row)
   );

   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_hs && !hsync_n) begin hs_fall_t = cyc; hs_fall_n++; end
         if (!p_hs && hsync_n) begin hs_rise_t = cyc; hs_rise_n++; end
         if (p_vs && !vsync_n) begin vs_fall_t = cyc; vs_fall_n++; end
         if (!p_vs && vsync_n) begin vs_rise_t = cyc; vs_rise_n++; end
         if (!p_von && video_on) begin von_rise_t = cyc; von_rise_n++; end
         if (p_von && !video_on) begin von_fall_t = cyc; von_fall_n++; end
         if (video_on) von_hi_n++;
      end
      p_hs = hsync_n;
      p_vs = vsync_n;
      p_von = video_on;
   end

   initial forever begin
      @(negedge clk);
      if (gate_mode) pix_en = ~pix_en;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic do_reset(input bit zs, input bit gated);
      gate_mode = 1'b0;
      pix_en = 1'b0;
      rst_n = 1'b0;
      restart_at_zero = zs;
      repeat (3) @(posedge clk);
      hs_fall_n = 0; hs_rise_n = 0; vs_fall_n = 0; vs_rise_n = 0;
      von_rise_n = 0; von_fall_n = 0; von_hi_n = 0;
      @(negedge clk);
      rst_n = 1'b1;
      pix_en = 1'b1;
      #1 gate_mode = gated;
   endtask

   task automatic test_reset();
      do_reset(1'b0, 1'b0);
      repeat (700) @(negedge clk);
      chk("R3", "hsync_n mid-sync before reset", int'(hsync_n), 0);
      rst_n = 1'b0;
      #1;
      chk("R1", "hsync_n in reset", int'(hsync_n), 1);
      chk("R1", "vsync_n in reset", int'(vsync_n), 1);
      chk("R1", "video_on in reset", int'(video_on), 0);
      @(negedge clk);
      chk("R1", "col+row in reset", int'(col) + int'(row), 0);
   endtask

   task automatic test_line();
      int bad_col = 0;
      int bad_blank = 0;
      int on_cnt = 0;
      do_reset(1'b0, 1'b0);
      for (int k = 1; k <= HT; k++) begin
         @(negedge clk);
         if (video_on) on_cnt++;
         if (k <= 640 && (!video_on || int'(col) != k - 1)) bad_col++;
         if (k > 640 && col != '0) bad_blank++;
      end
      chk("R4", "active pixels in first line", on_cnt, 640);
      chk("R4", "column sequence errors", bad_col, 0);
      chk("R6", "nonzero col in blanking", bad_blank, 0);
      chk("R4", "video_on fall enable", von_fall_t, 641);
      chk("R3", "first hsync fall enable", hs_fall_t, 657);
      chk("R3", "hsync width", hs_rise_t - hs_fall_t, 96);
      wait (von_rise_n == 2);
      chk("R3", "back porch", von_rise_t - hs_rise_t, 48);
      chk("R6", "row on second line", int'(row), 1);
      wait (hs_fall_n == 2);
      chk("R2", "hsync fall spacing", hs_fall_t, 657 + HT);
   endtask

   task automatic test_frame();
      int on_a, on_b, t_a;
      do_reset(1'b0, 1'b0);
      wait (vs_fall_n == 1);
      t_a = vs_fall_t;
      on_a = von_hi_n;
      chk("R5", "first vsync fall enable", vs_fall_t, (VA + VF) * HT + 1);
      chk("R6", "row outside active lines", int'(row), 0);
      wait (vs_rise_n == 1);
      chk("R5", "vsync width", vs_rise_t - t_a, VS * HT);
      wait (vs_fall_n == 2);
      on_b = von_hi_n;
      chk("R5", "frame length", vs_fall_t - t_a, VT * HT);
      chk("R6", "active pixels per frame", on_b - on_a, VA * 640);
   endtask

   task automatic test_gate();
      int bad_hold = 0;
      logic [COL_W-1:0] s_col;
      logic s_hs, s_vs, s_on;
      do_reset(1'b0, 1'b1);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         #1;
         if (!pix_en) begin
            s_col = col; s_hs = hsync_n; s_vs = vsync_n; s_on = video_on;
            @(negedge clk);
            if (col != s_col || hsync_n != s_hs || vsync_n != s_vs || video_on != s_on)
               bad_hold++;
         end
      end
      chk("R7", "outputs moved with pix_en low", bad_hold, 0);
      wait (hs_fall_n == 1);
      chk("R7", "hsync fall at half rate", hs_fall_t, 2 * 657 - 1);
      wait (hs_rise_n == 1);
      chk("R7", "hsync width at half rate", hs_rise_t - hs_fall_t, 192);
      wait (hs_fall_n == 2);
      chk("R7", "line period at half rate", hs_fall_t - (2 * 657 - 1), 2 * HT);
      gate_mode = 1'b0;
      pix_en = 1'b1;
   endtask

   task automatic test_zero();
      int bad_col = 0;
      int t_a;
      do_reset(1'b1, 1'b0);
      wait (von_rise_n == 2);
      chk("R8", "second line start enable", von_rise_t, HT);
      for (int i = 0; i <= 640; i++) begin
         if (!video_on || int'(col) != i) bad_col++;
         @(negedge clk);
      end
      chk("R8", "641-pixel column sequence errors", bad_col, 0);
      chk("R8", "video_on after pixel 640", int'(video_on), 0);
      wait (hs_fall_n == 2);
      t_a = hs_fall_t;
      wait (hs_rise_n == 2);
      chk("R8", "hsync width in zero mode", hs_rise_t - t_a, 96);
      wait (von_rise_n == 3);
      chk("R8", "back porch in zero mode", von_rise_t - hs_rise_t, 47);
      wait (hs_fall_n == 3);
      chk("R8", "line period in zero mode", hs_fall_t - t_a, HT);
      restart_at_zero = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      test_reset();
      test_line();
      test_frame();
      test_gate();
      test_zero();
      summary();
   end

endmodule